// File: doc/BRIEF.md
# Register-mapped UART port

This block is the bus side of a serial port. Software reaches it through eight 32-bit word registers on a simple read/write bus. Transmit bytes written by software are queued in a FIFO and handed to a separate serial engine over a valid/ready byte stream. Received bytes arrive from the engine with per-character error flags. They are queued in a second FIFO together with those flags and are read back by software. The block also produces the oversampling tick that paces the engine, passes the line settings to it, watches three modem status inputs, and combines several interrupt causes onto one interrupt line.

Software reads a character's status word before its data word, because reading the data pops the character. Errors seen by software stay latched until software writes the status register. Two control bits enable the receive interrupts: one for the fill level and one for the timeout. Of the interrupt causes, only the modem-change cause is cleared by a write to the interrupt register. The others follow the FIFO state.

Top module: `uart_reg_port`

## Requirements
- R1: After reset, control, line and divisor registers read 0, the interrupt register reads 0, `irq` is low, and with modem inputs low the flags register reads 0x90 (bit 7 TX empty, bit 4 RX empty).
- R2: Bytes written to the data register (offset 0x00) leave on `tx_byte` in write order, one per cycle with `tx_valid` and `tx_ready` high. `tx_valid` stays low while the enable bit (control bit 0) is clear.
- R3: With FIFOs enabled, the TX queue holds 16 bytes. Flags bit 5 (TX full) is set at 16, and a data write while full is discarded.
- R4: Received bytes read from offset 0x00 in arrival order. Each read pops one byte, and the byte is masked to the word length in line-control bits 6:5 (00 = 5 bits, 01 = 6, 10 = 7, 11 = 8).
- R5: The status register (offset 0x04) reads framing in bit 0, parity in bit 1, break in bit 2 and overrun in bit 3. Bits 2:0 show the head character's errors ORed with the errors of characters already popped. Any write to the status register clears the latched bits.
- R6: A character that arrives while the RX queue is full is discarded, the queued characters are kept, and status bit 3 is set.
- R7: With line-control bit 4 (FIFO enable) clear, each direction holds a single entry.
- R8: Interrupt bit 1 (receive) is pending while the RX queue holds at least 8 entries, or at least 1 when FIFOs are disabled. It is enabled by control bit 4.
- R9: Interrupt bit 3 (receive timeout) is pending when the RX queue is non-empty and no character has arrived for TMO_BITS bit periods. It clears when a character arrives. It is enabled by control bit 6.
- R10: Interrupt bit 2 (transmit) is pending while the TX queue holds 8 or fewer entries, or is empty when FIFOs are disabled. It is enabled by control bit 5.
- R11: Flags bits 0, 1 and 2 show the synchronised CTS, DSR and DCD inputs. Any change of these inputs latches interrupt bit 0 (modem), which is enabled by control bit 3. Any write to the interrupt register (offset 0x1C) clears it.
- R12: The interrupt register reads the pending causes ANDed with their enables, and `irq` is high exactly when that value is nonzero. A masked cause stays pending and appears once it is enabled.
- R13: Line control (0x08), divisor high (0x0C), divisor low (0x10) and control (0x14) read back what was written in their implemented bits. `line_cfg` mirrors line control. While enabled, `baud_tick` pulses once every divisor+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data, low byte used |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Byte available to the serial engine |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Engine accepts the byte |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 3 | Received errors: bit 0 framing, 1 parity, 2 break |
| cts_in | input | 1 | Clear-to-send modem input |
| dsr_in | input | 1 | Data-set-ready modem input |
| dcd_in | input | 1 | Carrier-detect modem input |
| line_cfg | output | 8 | Line-control settings for the engine |
| baud_tick | output | 1 | Oversampling tick for the engine |
| uart_on | output | 1 | Port enable for the engine |

## Verification
The bench builds the block with a 16-entry queue depth, 16 ticks per bit, and TMO_BITS reduced to 4. With the divisor set to 2, the receive timeout then expires about 192 cycles after the last arrival, so the wait can be run in full and its window tested on both sides. At depth 16, the full, overrun and half-level thresholds are reached after only a few dozen bus operations. The same depth leaves room for random bursts of up to twelve characters with random errors and word lengths.

// File: rtl/uart_reg_port.sv
module uart_reg_port #(
  parameter int DEPTH    = 16,  // power of two
  parameter int TMO_BITS = 32,
  parameter int OVS      = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic [2:0]  rx_err,
  input  logic        cts_in,
  input  logic        dsr_in,
  input  logic        dcd_in,
  output logic [7:0]  line_cfg,
  output logic        baud_tick,
  output logic        uart_on
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int HALF    = DEPTH / 2;
  localparam int TMO_LIM = TMO_BITS * OVS;
  localparam int TW      = $clog2(TMO_LIM + 1);

  localparam logic [2:0] A_DATA = 3'd0, A_RSTAT = 3'd1, A_LINE = 3'd2, A_DIVH = 3'd3,
                         A_DIVL = 3'd4, A_CTRL  = 3'd5, A_FLAG = 3'd6, A_INT  = 3'd7;

  logic [2:0] ra;
  logic       acc, wr, rd;
  assign ra  = bus_addr[4:2];
  assign acc = bus_en && (bus_addr[1:0] == 2'b00);
  assign wr  = acc && bus_we;
  assign rd  = acc && !bus_we;

  logic unused_hi;
  assign unused_hi = ^bus_wdata[31:8];

  logic [7:0] lcr, div_hi, div_lo, ctrl;
  logic       fen, en;
  assign fen      = lcr[4];
  assign en       = ctrl[0];
  assign line_cfg = lcr;
  assign uart_on  = en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcr <= '0; div_hi <= '0; div_lo <= '0; ctrl <= '0;
    end else if (wr) begin
      case (ra)
        A_LINE: lcr    <= bus_wdata[7:0] & 8'h7F;
        A_DIVH: div_hi <= bus_wdata[7:0];
        A_DIVL: div_lo <= bus_wdata[7:0];
        A_CTRL: ctrl   <= bus_wdata[7:0] & 8'h79;
        default: ;
      endcase
    end

  logic [CW-1:0] cap;
  assign cap = fen ? CW'(DEPTH) : CW'(1);

  // transmit queue
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_push, tx_pop;

  assign tx_full  = tx_cnt >= cap;
  assign tx_push  = wr && ra == A_DATA && !tx_full;
  assign tx_valid = en && tx_cnt != '0;
  assign tx_byte  = tx_mem[tx_rp];
  assign tx_pop   = tx_valid && tx_ready;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  // R3
  tx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !tx_pop) |=> tx_cnt == $past(tx_cnt) + CW'(1));

  // receive queue: {err[2:0], byte}
  logic [10:0]   rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_push, rx_drop, rx_pop, rx_empty;
  logic [10:0]   rx_head;
  logic [2:0]    head_err, err_lat;
  logic          ovr;
  logic [7:0]    wl_mask;

  assign rx_empty = rx_cnt == '0;
  assign rx_full  = rx_cnt >= cap;
  assign rx_push  = rx_valid && en && !rx_full;
  assign rx_drop  = rx_valid && en && rx_full;
  assign rx_pop   = rd && ra == A_DATA && !rx_empty;
  assign rx_head  = rx_mem[rx_rp];
  assign head_err = rx_empty ? 3'b000 : rx_head[10:8];
  assign wl_mask  = 8'hFF >> (2'd3 - lcr[6:5]);

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= {rx_err, rx_byte};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_lat <= '0; ovr <= 1'b0;
    end else begin
      if (wr && ra == A_RSTAT) err_lat <= '0;
      else if (rx_pop)         err_lat <= err_lat | head_err;
      if (rx_drop)                  ovr <= 1'b1;
      else if (wr && ra == A_RSTAT) ovr <= 1'b0;
    end

  // R6
  rx_drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_pop) |=> (rx_cnt == $past(rx_cnt) && ovr));

  // R5
  rs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ra == A_RSTAT && !rx_drop) |=> (err_lat == 3'b000 && !ovr));

  // R6
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  // baud tick and receive timeout
  logic [15:0]   pre;
  logic [TW-1:0] tmo;
  logic          rto;

  assign baud_tick = en && pre == {div_hi, div_lo};
  assign rto       = tmo == TW'(TMO_LIM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         pre <= '0;
    else if (!en)       pre <= '0;
    else if (baud_tick) pre <= '0;
    else                pre <= pre + 16'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  tmo <= '0;
    else if (rx_push || rx_empty) tmo <= '0;
    else if (baud_tick && !rto)  tmo <= tmo + TW'(1);

  // R9
  rto_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rto);

  // modem inputs
  logic [2:0] m1, m2, mp;
  logic       mis;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; mp <= '0; mis <= 1'b0;
    end else begin
      m1 <= {dcd_in, dsr_in, cts_in};
      m2 <= m1;
      mp <= m2;
      if (m2 != mp)              mis <= 1'b1;
      else if (wr && ra == A_INT) mis <= 1'b0;
    end

  // interrupts
  logic [3:0] raw, ir;
  logic       ris, tis;
  assign ris = rx_cnt >= (fen ? CW'(HALF) : CW'(1));
  assign tis = tx_cnt <= (fen ? CW'(HALF) : CW'(0));
  assign raw = {rto, tis, ris, mis};
  assign ir  = raw & {ctrl[6], ctrl[5], ctrl[4], ctrl[3]};
  assign irq = |ir;

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6:3] == 4'b0000) |-> !irq);

  always_comb begin
    bus_rdata = '0;
    case (ra)
      A_DATA:  bus_rdata[7:0] = rx_head[7:0] & wl_mask;
      A_RSTAT: bus_rdata[3:0] = {ovr, err_lat | head_err};
      A_LINE:  bus_rdata[7:0] = lcr;
      A_DIVH:  bus_rdata[7:0] = div_hi;
      A_DIVL:  bus_rdata[7:0] = div_lo;
      A_CTRL:  bus_rdata[7:0] = ctrl;
      A_FLAG:  bus_rdata[7:0] = {tx_cnt == '0, 1'b0, tx_full, rx_empty, 1'b0, m2};
      A_INT:   bus_rdata[3:0] = ir;
      default: ;
    endcase
  end
endmodule

// File: tb/sim_uart_reg_port.sv
`timescale 1ns/1ps
module sim_uart_reg_port;
  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq, tx_valid, tx_ready = 0, rx_valid = 0;
  logic [7:0]  tx_byte, rx_byte = 0, line_cfg;
  logic [2:0]  rx_err = 0;
  logic        cts_in = 0, dsr_in = 0, dcd_in = 0, baud_tick, uart_on;

  int checks = 0, errors = 0;

  uart_reg_port #(.DEPTH(16), .TMO_BITS(4), .OVS(16)) u0 (.*);

  always #10 clk = ~clk;

  localparam logic [4:0] DATA = 5'h00, RSTAT = 5'h04, LINE = 5'h08, DIVH = 5'h0C,
                         DIVL = 5'h10, CTRL = 5'h14, FLAG = 5'h18, INTR = 5'h1C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic [2:0] e);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_err = e;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic tx_take(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk({tag, " tx_valid"}, {31'b0, tx_valid}, 1);
    chk({tag, " tx_byte"}, {24'b0, tx_byte}, {24'b0, exp});
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  function automatic logic [7:0] wmask(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  tq [32];
    logic [7:0]  rb [16];
    logic [2:0]  re [16];
    logic [2:0]  lat;
    int          ticks;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk); rst_n = 1;
    // R1
    rd(FLAG, d); chk("R1 flags", d, 32'h90);
    rd(CTRL, d); chk("R1 ctrl", d, 0);
    rd(INTR, d); chk("R1 int", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R13
    wr(LINE, 32'h70); wr(DIVH, 32'h00); wr(DIVL, 32'h02); wr(CTRL, 32'h01);
    rd(LINE, d); chk("R13 line", d, 32'h70);
    rd(DIVL, d); chk("R13 divlo", d, 32'h02);
    rd(CTRL, d); chk("R13 ctrl", d, 32'h01);
    chk("R13 line_cfg", {24'b0, line_cfg}, 32'h70);
    ticks = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (baud_tick) ticks++; end
    chk("R13 tick count", ticks, 10);

    // R2 hold while disabled
    wr(CTRL, 32'h00); wr(DATA, 32'h5A);
    @(negedge clk); chk("R2 disabled hold", {31'b0, tx_valid}, 0);
    wr(CTRL, 32'h01);
    tx_take(8'h5A, "R2 after enable");

    // R2 R3 fill, full, drop
    for (int i = 0; i < 16; i++) begin tq[i] = 8'($urandom); wr(DATA, {24'b0, tq[i]}); end
    rd(FLAG, d); chk("R3 full flags", d, 32'h30);
    wr(DATA, 32'hEE);
    for (int i = 0; i < 16; i++) tx_take(tq[i], "R2 order");
    @(negedge clk); chk("R3 extra dropped", {31'b0, tx_valid}, 0);
    rd(FLAG, d); chk("R2 flags empty", d, 32'h90);

    // R10
    wr(CTRL, 32'h21);
    rd(INTR, d); chk("R10 tx int empty", d, 32'h04);
    chk("R10 irq", {31'b0, irq}, 1);
    for (int i = 0; i < 9; i++) begin tq[i] = 8'(i + 3); wr(DATA, {24'b0, tq[i]}); end
    rd(INTR, d); chk("R10 above half", d, 0);
    tx_take(tq[0], "R10 drain");
    rd(INTR, d); chk("R10 at half", d, 32'h04);
    for (int i = 1; i < 9; i++) tx_take(tq[i], "R10 drain");
    wr(CTRL, 32'h01);

    // R4 R5 random bursts
    for (int r = 0; r < 6; r++) begin
      logic [1:0] wl;
      int n;
      wl = 2'($urandom);
      wr(LINE, {25'b0, wl, 1'b1, 4'b0});
      wr(RSTAT, 32'hFF);
      lat = 0;
      n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++) begin
        rb[i] = 8'($urandom);
        re[i] = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
        rx_send(rb[i], re[i]);
      end
      for (int i = 0; i < n; i++) begin
        rd(RSTAT, d); chk("R5 status", d, {29'b0, lat | re[i]});
        rd(DATA, d);  chk("R4 data", d, {24'b0, rb[i] & wmask(wl)});
        lat = lat | re[i];
      end
      rd(RSTAT, d); chk("R5 latched after drain", d, {29'b0, lat});
      wr(RSTAT, 32'h0);
      rd(RSTAT, d); chk("R5 cleared", d, 0);
    end

    // R6
    wr(LINE, 32'h70);
    for (int i = 0; i < 16; i++) begin rb[i] = 8'(8'h40 + i); rx_send(rb[i], 0); end
    rx_send(8'hC3, 0);
    rd(RSTAT, d); chk("R6 overrun bit", d, 32'h08);
    for (int i = 0; i < 16; i++) begin rd(DATA, d); chk("R6 kept", d, {24'b0, rb[i]}); end
    rd(FLAG, d); chk("R6 newest dropped", d, 32'h90);
    wr(RSTAT, 0);

    // R7
    wr(LINE, 32'h60);
    rx_send(8'h11, 0); rx_send(8'h22, 0);
    rd(RSTAT, d); chk("R7 rx single overrun", d, 32'h08);
    rd(DATA, d);  chk("R7 rx single data", d, 32'h11);
    rd(FLAG, d);  chk("R7 rx empty", d, 32'h90);
    wr(RSTAT, 0);
    wr(DATA, 32'h33);
    rd(FLAG, d);  chk("R7 tx full at one", d, 32'h30);
    wr(DATA, 32'h44);
    tx_take(8'h33, "R7 tx");
    @(negedge clk); chk("R7 tx second dropped", {31'b0, tx_valid}, 0);

    // R8
    wr(LINE, 32'h70); wr(CTRL, 32'h11);
    for (int i = 0; i < 7; i++) rx_send(8'(i), 0);
    rd(INTR, d); chk("R8 below half", d, 0);
    rx_send(8'h07, 0);
    rd(INTR, d); chk("R8 at half", d, 32'h02);
    chk("R8 irq", {31'b0, irq}, 1);
    rd(DATA, d);
    rd(INTR, d); chk("R8 after pop", d, 0);
    for (int i = 0; i < 7; i++) rd(DATA, d);
    rd(FLAG, d); chk("R8 drained", d, 32'h90);

    // R9 (TMO_BITS 4, divisor 2: about 192 cycles)
    wr(CTRL, 32'h41);
    rx_send(8'hA1, 0);
    repeat (150) @(negedge clk);
    rd(INTR, d); chk("R9 before timeout", d, 0);
    repeat (60) @(negedge clk);
    rd(INTR, d); chk("R9 timeout", d, 32'h08);
    chk("R9 irq", {31'b0, irq}, 1);
    rx_send(8'hA2, 0);
    rd(INTR, d); chk("R9 cleared by arrival", d, 0);
    rd(DATA, d); rd(DATA, d);

    // R11 R12
    wr(CTRL, 32'h09);
    cts_in = 1; repeat (5) @(negedge clk);
    rd(FLAG, d); chk("R11 cts flag", d, 32'h91);
    rd(INTR, d); chk("R11 modem int", d, 32'h01);
    wr(INTR, 32'hFF);
    rd(INTR, d); chk("R11 cleared", d, 0);
    chk("R11 irq low", {31'b0, irq}, 0);
    wr(CTRL, 32'h01);
    dsr_in = 1; repeat (5) @(negedge clk);
    rd(INTR, d); chk("R12 masked", d, 0);
    chk("R12 irq masked", {31'b0, irq}, 0);
    rd(FLAG, d); chk("R11 dsr flag", d, 32'h93);
    wr(CTRL, 32'h79);
    rd(INTR, d); chk("R12 combined", d, 32'h05);
    chk("R12 irq", {31'b0, irq}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule